// File: doc/BRIEF.md
# Serial Flash Write-Protection and Status Unit

This block holds the status byte of a serial flash device and decides, cycle by cycle, whether each decoded write-class command may go ahead. A command decoder presents one-cycle strobes for write enable, write disable, status write, page program, sector erase and bulk erase, together with the target address and the data byte of a status write. The block answers in the same cycle with one grant pulse per command. An array engine that sees a grant runs the long program or erase operation and reports it on its busy flag.

Three conditions gate each write: a write-enable latch, a three-bit software protect code that fences off an upper region of the array, and a hardware lock. The hardware lock is formed when the status-protect bit is set and the write-protect pin is driven low. The protect code and the status-protect bit act as the device's non-volatile bits and are kept in registers here. Serial shifting and the array itself are handled elsewhere.

All pins are plain control and status pins with no valid/ready handshake. A strobe is a request that is either granted or dropped in its own cycle, and the block never stalls a requester.

Top module: `flash_wr_guard`

## Requirements
- R1: The status byte reads busy in bit 0, the write-enable latch in bit 1, the protect code in bits 4:2 (bit 2 is its LSB), zero in bits 6:5, and the status-protect bit in bit 7. After reset, with the default initial values, it reads 0x00.
- R2: A granted write enable sets the latch and a granted write disable clears it. A status write, page program, sector erase or bulk erase is not granted while the latch is 0.
- R3: Protect code 0 fences nothing and code 7 fences the whole array. A code k from 1 to 6 fences the top min(k x 64 KB, array size) bytes. A page program or sector erase whose address lies in the fenced region is not granted.
- R4: A granted status write loads the protect code from data bits 4:2 and the status-protect bit from data bit 7. Data bits 6:5 and 1:0 have no effect on the status byte.
- R5: While the status-protect bit is 1 and wp_n_i is 0, a status write is not granted and the protect code and status-protect bit keep their values. With wp_n_i at 1, a status write is granted even when the status-protect bit is 1.
- R6: A bulk erase is granted only while the protect code is 0.
- R7: The busy bit reads 1 from the cycle after any granted status write, program or erase until the cycle after eng_busy_i falls, having been high. It also reads 1 whenever eng_busy_i is high.
- R8: When an accepted status write, program or erase cycle completes, the write-enable latch is cleared.
- R9: While the busy bit reads 1, none of the six commands is granted, so the latch and the non-volatile bits are left unchanged.
- R10: If more than one command strobe is high in a cycle, none is granted and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| wrsr_data_i | input | 8 | Data byte of a status write |
| pp_i | input | 1 | Page-program command strobe |
| se_i | input | 1 | Sector-erase command strobe |
| be_i | input | 1 | Bulk-erase command strobe |
| addr_i | input | ADDR_W | Byte address of a program or erase |
| wp_n_i | input | 1 | Write-protect pin, active low |
| eng_busy_i | input | 1 | Array engine busy flag |
| status_o | output | 8 | Status byte for reads |
| wren_ok_o | output | 1 | Write enable granted |
| wrdi_ok_o | output | 1 | Write disable granted |
| wrsr_ok_o | output | 1 | Status write granted |
| pp_ok_o | output | 1 | Page program granted |
| se_ok_o | output | 1 | Sector erase granted |
| be_ok_o | output | 1 | Bulk erase granted |

## Verification
A wrong write-enable latch or protect code shows up in two places. It appears in status_o on the next cycle, and it also appears as a grant that is wrongly given or withheld on the very next strobe. The bench therefore reads the status byte after every state change and tries every command against it. A busy tracker stuck high withholds all grants from then on, and one that clears early lets the latch survive the completed cycle. Both cases are caught by reading the status byte one cycle after the engine busy flag falls. The fence boundary is swept at every 4 KB sector start and end for all eight codes, so an off-by-one in the region compare appears as a single wrong grant.

// File: rtl/flash_wr_guard_pkg.sv
package flash_wr_guard_pkg;

  localparam int SR_BUSY  = 0;
  localparam int SR_WEL   = 1;
  localparam int SR_BP_LO = 2;
  localparam int BP_W     = 3;
  localparam int SR_SRP   = 7;

  localparam logic [BP_W-1:0] BP_NONE = '0;
  localparam logic [BP_W-1:0] BP_ALL  = '1;

  typedef struct packed {
    logic            srp;
    logic [BP_W-1:0] bp;
  } nv_bits_t;

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel, logic busy);
    logic [7:0] s;
    s = '0;
    s[SR_BUSY] = busy;
    s[SR_WEL] = wel;
    s[SR_BP_LO +: BP_W] = nv.bp;
    s[SR_SRP] = nv.srp;
    return s;
  endfunction

endpackage

// File: rtl/fwg_nv_bits.sv
module fwg_nv_bits
  import flash_wr_guard_pkg::*;
#(
  parameter logic [BP_W-1:0] INIT_BP  = '0,
  parameter logic            INIT_SRP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wp_n,
  output nv_bits_t   nv,
  output logic       hw_lock
);

  logic unused_data;
  assign unused_data = ^{wr_data[6:5], wr_data[1:0]};

  assign hw_lock = nv.srp & ~wp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv.srp <= INIT_SRP;
      nv.bp  <= INIT_BP;
    end else if (wr_en) begin
      nv.srp <= wr_data[SR_SRP];
      nv.bp  <= wr_data[SR_BP_LO +: BP_W];
    end
  end

  // R5: locked bits hold across a locked cycle
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> $stable(nv));

endmodule

// File: rtl/fwg_wel.sv
module fwg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  output logic wel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wel <= 1'b0;
    else if (clr_i || done_i) wel <= 1'b0;
    else if (set_i)          wel <= 1'b1;
  end

  // R2: granted write enable sets the latch
  a_r2_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !done_i) |=> wel);

  // R8: completion clears the latch
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel);

endmodule

// File: rtl/fwg_cycle.sv
module fwg_cycle (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic eng_busy_i,
  output logic active_o,
  output logic done_o
);

  logic seen_q;

  assign done_o = active_o & seen_q & ~eng_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      seen_q   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      seen_q   <= 1'b0;
    end else if (done_o) begin
      active_o <= 1'b0;
      seen_q   <= 1'b0;
    end else if (active_o && eng_busy_i) begin
      seen_q   <= 1'b1;
    end
  end

  // R7: a started cycle is tracked from the next cycle on
  a_r7_start_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);

  // R9: no new cycle starts while one is tracked
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_o);

endmodule

// File: rtl/fwg_region.sv
module fwg_region
  import flash_wr_guard_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int STEP_LG = 16
) (
  input  logic [BP_W-1:0]   code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int W = ADDR_W + BP_W + 1;
  localparam logic [W-1:0] ARRAY = {{(W-1){1'b0}}, 1'b1} << ADDR_W;

  logic [W-1:0] step_span;
  logic [W-1:0] span;

  always_comb begin
    step_span = W'(code_i) << STEP_LG;
    if (code_i == BP_ALL)      span = ARRAY;
    else if (step_span > ARRAY) span = ARRAY;
    else                        span = step_span;
    hit_o = (W'(addr_i) + span) >= ARRAY;
  end

  // R3: code 0 fences nothing, code 7 fences everything
  always_comb begin
    a_r3_code_ends: assert ((code_i != BP_NONE || !hit_o) && (code_i != BP_ALL || hit_o));
  end

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import flash_wr_guard_pkg::*;
#(
  parameter int              ADDR_W   = 18,
  parameter int              STEP_LG  = 16,
  parameter logic [BP_W-1:0] INIT_BP  = '0,
  parameter logic            INIT_SRP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              pp_i,
  input  logic              se_i,
  input  logic              be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              eng_busy_i,
  output logic [7:0]        status_o,
  output logic              wren_ok_o,
  output logic              wrdi_ok_o,
  output logic              wrsr_ok_o,
  output logic              pp_ok_o,
  output logic              se_ok_o,
  output logic              be_ok_o
);

  localparam int N_CMD = 6;

  nv_bits_t nv;
  logic     hw_lock;
  logic     wel;
  logic     cyc_active;
  logic     cyc_done;
  logic     busy_bit;
  logic     fenced;
  logic     lone;
  logic     go;
  logic     wr_ok;
  logic     cyc_start;

  assign busy_bit = eng_busy_i | cyc_active;
  assign lone     = $countones({wren_i, wrdi_i, wrsr_i, pp_i, se_i, be_i}) <= 1;
  assign go       = lone & ~busy_bit;
  assign wr_ok    = go & wel;

  assign wren_ok_o = go & wren_i;
  assign wrdi_ok_o = go & wrdi_i;
  assign wrsr_ok_o = wr_ok & wrsr_i & ~hw_lock;
  assign pp_ok_o   = wr_ok & pp_i & ~fenced;
  assign se_ok_o   = wr_ok & se_i & ~fenced;
  assign be_ok_o   = wr_ok & be_i & (nv.bp == BP_NONE);

  assign cyc_start = wrsr_ok_o | pp_ok_o | se_ok_o | be_ok_o;

  assign status_o = pack_status(nv, wel, busy_bit);

  fwg_nv_bits #(.INIT_BP(INIT_BP), .INIT_SRP(INIT_SRP)) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wrsr_ok_o),
    .wr_data (wrsr_data_i),
    .wp_n    (wp_n_i),
    .nv      (nv),
    .hw_lock (hw_lock)
  );

  fwg_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wren_ok_o),
    .clr_i  (wrdi_ok_o),
    .done_i (cyc_done),
    .wel    (wel)
  );

  fwg_cycle u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (cyc_start),
    .eng_busy_i (eng_busy_i),
    .active_o   (cyc_active),
    .done_o     (cyc_done)
  );

  fwg_region #(.ADDR_W(ADDR_W), .STEP_LG(STEP_LG)) u_region (
    .code_i (nv.bp),
    .addr_i (addr_i),
    .hit_o  (fenced)
  );

  // R2: write-class grants need the latch as held by its own register
  a_r2_need_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> status_o[SR_WEL]);

  // R6: bulk erase only with an empty protect code
  a_r6_be_open: assert property (@(posedge clk) disable iff (!rst_n)
    be_ok_o |-> (status_o[SR_BP_LO +: BP_W] == BP_NONE));

  // R7: busy bit rises after a grant
  a_r7_busy_after: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> status_o[SR_BUSY]);

  // R9: nothing granted while busy
  a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[SR_BUSY] |-> !(wren_ok_o | wrdi_ok_o | wrsr_ok_o | pp_ok_o | se_ok_o | be_ok_o));

  // R10: at most one grant and none on a multi-strobe cycle
  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wren_ok_o, wrdi_ok_o, wrsr_ok_o, pp_ok_o, se_ok_o, be_ok_o}));
  a_r10_multi_none: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({wren_i, wrdi_i, wrsr_i, pp_i, se_i, be_i}) > 1) |=> $stable(status_o[7:1]));

  logic unused_n;
  assign unused_n = (N_CMD == 6);

endmodule

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;

  localparam int AW = 18;
  localparam int ARRAY = 1 << AW;
  localparam int STEP = 1 << 16;

  localparam logic [5:0] M_WREN = 6'b100000;
  localparam logic [5:0] M_WRDI = 6'b010000;
  localparam logic [5:0] M_WRSR = 6'b001000;
  localparam logic [5:0] M_PP   = 6'b000100;
  localparam logic [5:0] M_SE   = 6'b000010;
  localparam logic [5:0] M_BE   = 6'b000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren = 0, wrdi = 0, wrsr = 0, pp = 0, se = 0, be = 0;
  logic [7:0] wdata = '0;
  logic [AW-1:0] addr = '0;
  logic wp_n = 1'b1;
  logic eng_busy = 1'b0;
  logic [7:0] status;
  logic wren_ok, wrdi_ok, wrsr_ok, pp_ok, se_ok, be_ok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_wr_guard u_flash_wr_guard (
    .clk(clk), .rst_n(rst_n),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wdata),
    .pp_i(pp), .se_i(se), .be_i(be), .addr_i(addr),
    .wp_n_i(wp_n), .eng_busy_i(eng_busy),
    .status_o(status),
    .wren_ok_o(wren_ok), .wrdi_ok_o(wrdi_ok), .wrsr_ok_o(wrsr_ok),
    .pp_ok_o(pp_ok), .se_ok_o(se_ok), .be_ok_o(be_ok)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] m, input int a, input logic [7:0] d,
                       output logic [5:0] g);
    @(negedge clk);
    {wren, wrdi, wrsr, pp, se, be} = m;
    addr = AW'(a);
    wdata = d;
    #1;
    g = {wren_ok, wrdi_ok, wrsr_ok, pp_ok, se_ok, be_ok};
    @(negedge clk);
    {wren, wrdi, wrsr, pp, se, be} = '0;
  endtask

  task automatic finish_cycle();
    eng_busy = 1'b1;
    repeat (3) @(negedge clk);
    eng_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sr(input logic [7:0] d);
    logic [5:0] g;
    issue(M_WREN, 0, 8'h00, g);
    issue(M_WRSR, 0, d, g);
    check(g == M_WRSR, "R4 status write grant", g, M_WRSR);
    finish_cycle();
  endtask

  function automatic bit fenced(input int code, input int a);
    int span;
    if (code == 7) span = ARRAY;
    else span = (code * STEP > ARRAY) ? ARRAY : code * STEP;
    return a >= ARRAY - span;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] g;
    logic [7:0] exp_s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1 reset status", status, 8'h00);

    // R2: without the latch nothing write-class is granted
    issue(M_PP, 0, 8'h00, g);
    check(g == 0, "R2 program without latch", g, 0);
    issue(M_WRSR, 0, 8'h1C, g);
    check(g == 0, "R2 status write without latch", g, 0);
    issue(M_WREN, 0, 8'h00, g);
    check(g == M_WREN && status == 8'h02, "R2 write enable sets latch", status, 8'h02);
    issue(M_WRDI, 0, 8'h00, g);
    check(g == M_WRDI && status == 8'h00, "R2 write disable clears latch", status, 8'h00);

    // R4: field loading, ignored bits
    set_sr(8'h7F);
    check(status == 8'h1C, "R4 R1 R8 load code, reserved zero", status, 8'h1C);
    set_sr(8'hE3);
    check(status == 8'h80, "R4 load protect bit only", status, 8'h80);

    // R5: hardware lock
    wp_n = 1'b0;
    issue(M_WREN, 0, 8'h00, g);
    issue(M_WRSR, 0, 8'h00, g);
    check(g == 0, "R5 locked status write", g, 0);
    @(negedge clk);
    check(status == 8'h82, "R5 locked bits kept", status, 8'h82);
    wp_n = 1'b1;
    issue(M_WRSR, 0, 8'h00, g);
    check(g == M_WRSR, "R5 unlocked status write", g, M_WRSR);
    finish_cycle();
    check(status == 8'h00, "R5 R8 unlocked write result", status, 8'h00);

    // R7 R9: busy blocks everything
    issue(M_WREN, 0, 8'h00, g);
    issue(M_PP, 0, 8'h00, g);
    check(g == M_PP, "R7 program grant", g, M_PP);
    check(status == 8'h03, "R7 busy right after grant", status, 8'h03);
    issue(M_WRDI, 0, 8'h00, g);
    check(g == 0, "R9 write disable while busy", g, 0);
    check(status == 8'h03, "R9 latch kept while busy", status, 8'h03);
    finish_cycle();
    check(status == 8'h00, "R7 R8 cycle completes", status, 8'h00);
    @(negedge clk);
    eng_busy = 1'b1;
    #1;
    check(status == 8'h01, "R7 engine busy reported", status, 8'h01);
    issue(M_WREN, 0, 8'h00, g);
    check(g == 0, "R9 write enable while engine busy", g, 0);
    eng_busy = 1'b0;
    @(negedge clk);
    check(status == 8'h00, "R9 latch untouched", status, 8'h00);

    // R10: multiple strobes
    issue(M_WREN | M_WRDI, 0, 8'h00, g);
    check(g == 0 && status == 8'h00, "R10 two strobes", status, 8'h00);
    issue(M_WREN, 0, 8'h00, g);
    issue(M_PP | M_BE, 0, 8'h00, g);
    check(g == 0 && status == 8'h02, "R10 two write strobes", status, 8'h02);
    issue(M_WRDI, 0, 8'h00, g);

    // R3 R6: sweep every code over sector boundaries
    for (int code = 0; code < 8; code++) begin
      set_sr(8'(code << 2));
      exp_s = 8'(code << 2);
      check(status == exp_s, "R1 code readback", status, exp_s);
      issue(M_WREN, 0, 8'h00, g);
      issue(M_BE, 0, 8'h00, g);
      check((g == M_BE) == (code == 0), "R6 bulk erase gate", g, (code == 0) ? M_BE : 0);
      if (g != 0) finish_cycle(); else issue(M_WRDI, 0, 8'h00, g);
      for (int i = 0; i < 64; i++) begin
        for (int k = 0; k < 2; k++) begin
          int a;
          logic [5:0] op;
          bit exp_g;
          a = i * 4096 + k * 4095;
          op = i[0] ? M_SE : M_PP;
          exp_g = !fenced(code, a);
          issue(M_WREN, 0, 8'h00, g);
          issue(op, a, 8'h00, g);
          check((g == op) == exp_g, "R3 fence decision", g, exp_g ? op : 0);
          if (g != 0) finish_cycle(); else issue(M_WRDI, 0, 8'h00, g);
        end
      end
      check(status == exp_s, "R8 latch clear after sweep", status, exp_s);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule